// File: doc/BRIEF.md
# Chunked SPI Flash Read Sequencer

This block turns one read request into a series of short flash read bursts and streams the returned data out. A request is a 24-bit flash address and a byte count. The sequencer splits the request into pieces that fit the receive FIFO of the SPI master beneath it. For each piece it sets the master's counters and pushes the four-byte read header. It then starts the exchange and waits for the whole burst to land in the receive FIFO. It drops the four bytes clocked in while the header was going out, and hands the payload to a valid/ready stream.

Between bursts the flash must see chip select deasserted for a minimum time. The sequencer keeps a deselect timer that starts when a burst is seen complete. No new exchange begins until that timer has run out and the previous payload has fully drained. A done pulse marks the end of each request. A request with a count of zero finishes without touching the master.

Top module: `spi_flash_chunk_reader`

## Requirements
- R1: Before each exchange start, exactly four bytes are pushed to the master in this order: opcode 0x03, address bits 23:16, address bits 15:8, address bits 7:0.
- R2: Each burst carries at most FIFO_DEPTH-4 payload bytes (60 by default). A request is cut into full bursts of that size, followed by one shorter remainder burst if one is needed.
- R3: At the cycle the exchange start is pulsed, the burst count output equals 4 plus the payload length of that burst, and the transmit count output equals 4.
- R4: No byte is popped from the receive FIFO until its fill level has reached the burst count of the current burst.
- R5: The first four bytes popped in each burst are discarded. The remaining bytes appear on the output stream in FIFO order, and nothing else appears there.
- R6: At least GAP_CYC clock cycles (20 by default, 100 ns at 200 MHz) pass between the cycle in which a burst is seen complete and the next exchange start.
- R7: After each burst, the address for the next burst is the previous address plus the payload length, modulo 2^24. The remaining length drops by the same amount.
- R8: A request with length 0 raises done in the cycle after it is accepted, with no header push, no start and no pop.
- R9: Done is high for exactly one cycle, in the cycle after the final payload byte of a request is accepted downstream, and at no other time.
- R10: While out_valid is high and out_ready is low, the receive FIFO is not popped and out_valid stays high.
- R11: After reset, req_ready is 1, and out_valid, done, header push, exchange start and pop are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_addr | input | 24 | First flash byte address |
| req_len | input | LEN_W (16) | Number of bytes to read |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Payload byte |
| done | output | 1 | One-cycle pulse at request completion |
| mst_burst_cnt | output | LVL_W (7) | Total bytes of the exchange |
| mst_xfer_cnt | output | LVL_W (7) | Bytes to transmit in the exchange |
| mst_tx_data | output | 8 | Header byte for the transmit FIFO |
| mst_tx_push | output | 1 | Push mst_tx_data into the transmit FIFO |
| mst_start | output | 1 | Start-exchange pulse |
| mst_rx_level | input | LVL_W (7) | Receive FIFO fill level |
| mst_rx_data | input | 8 | Receive FIFO head byte (show-ahead) |
| mst_rx_pop | output | 1 | Pop the receive FIFO head |

## Verification
Two events can land in the same stretch of cycles: the deselect timer running out, and the payload draining. The next start must wait for the later of the two. The bench covers both orders. With out_ready held high, short remainder bursts drain before the timer expires. With out_ready mostly low, a burst's payload is still draining long after the timer has expired. In both cases the reference model counts cycles from the moment the modelled FIFO holds the full burst. It rejects any start that comes too early, and any pop made while the stream is stalled.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  localparam int HDR_BYTES = 4;
  localparam logic [7:0] READ_OPCODE = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_LOAD,
    ST_GO,
    ST_WAIT,
    ST_DRAIN
  } seq_state_e;

  // Header byte for slot idx: opcode, then the address from the top byte down.
  function automatic logic [7:0] hdr_byte(input logic [23:0] addr, input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = READ_OPCODE;
      2'd1:    b = addr[23:16];
      2'd2:    b = addr[15:8];
      default: b = addr[7:0];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/sfr_chunk_plan.sv
module sfr_chunk_plan #(
  parameter int LEN_W     = 16,
  parameter int LVL_W     = 7,
  parameter int CHUNK_MAX = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic [23:0]      ld_addr,
  input  logic [LEN_W-1:0] ld_len,
  output logic [23:0]      cur_addr,
  output logic [LVL_W-1:0] chunk_len,
  output logic             last_chunk
);

  logic [LEN_W-1:0] remain;

  function automatic logic [LVL_W-1:0] clip_len(input logic [LEN_W-1:0] r);
    if (r > LEN_W'(CHUNK_MAX)) return LVL_W'(CHUNK_MAX);
    return LVL_W'(r);
  endfunction

  assign chunk_len  = clip_len(remain);
  assign last_chunk = (remain <= LEN_W'(CHUNK_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      remain   <= ld_len;
    end else if (advance) begin
      cur_addr <= cur_addr + 24'(chunk_len);
      remain   <= remain - LEN_W'(chunk_len);
    end
  end

  // R2: the planned burst never exceeds the FIFO room left after the header
  a_r2_chunk_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chunk_len) <= CHUNK_MAX);

  // R7: an advance moves the address by exactly the burst just finished
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load) |=> (cur_addr == $past(cur_addr) + 24'($past(chunk_len))));

endmodule

// File: rtl/sfr_gap_timer.sv
module sfr_gap_timer #(
  parameter int GAP_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic elapsed
);

  localparam int CW = $clog2(GAP_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= CW'(GAP_CYC);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign elapsed = (cnt == '0);

  // R6: the countdown never runs above the configured deselect time
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= GAP_CYC);

  // R6: a running countdown keeps going down until it reaches zero or is restarted
  a_r6_cnt_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/spi_flash_chunk_reader.sv
module spi_flash_chunk_reader #(
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int GAP_CYC    = 20,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done,
  output logic [LVL_W-1:0] mst_burst_cnt,
  output logic [LVL_W-1:0] mst_xfer_cnt,
  output logic [7:0]       mst_tx_data,
  output logic             mst_tx_push,
  output logic             mst_start,
  input  logic [LVL_W-1:0] mst_rx_level,
  input  logic [7:0]       mst_rx_data,
  output logic             mst_rx_pop
);

  import sfr_pkg::*;

  localparam int CHUNK_MAX = FIFO_DEPTH - HDR_BYTES;
  localparam int GW        = $clog2(GAP_CYC + 1);

  seq_state_e       state;
  logic [LVL_W-1:0] pos;
  logic [LVL_W-1:0] chunk_len;
  logic [LVL_W-1:0] burst;
  logic [23:0]      cur_addr;
  logic             last_chunk;
  logic             gap_elapsed;

  // named internal events
  logic accept, zero_req, fill_ok, gap_start, in_hdr, last_pop, plan_load, plan_adv;

  assign burst     = chunk_len + LVL_W'(HDR_BYTES);
  assign accept    = req_valid && req_ready;
  assign zero_req  = accept && (req_len == '0);
  assign fill_ok   = (mst_rx_level >= burst);
  assign gap_start = (state == ST_WAIT) && fill_ok;
  assign in_hdr    = (pos < LVL_W'(HDR_BYTES));

  assign req_ready     = (state == ST_IDLE);
  assign mst_tx_push   = (state == ST_LOAD);
  assign mst_tx_data   = hdr_byte(cur_addr, pos[1:0]);
  assign mst_start     = (state == ST_GO);
  assign mst_burst_cnt = burst;
  assign mst_xfer_cnt  = LVL_W'(HDR_BYTES);
  assign out_valid     = (state == ST_DRAIN) && !in_hdr;
  assign out_data      = mst_rx_data;
  assign mst_rx_pop    = (state == ST_DRAIN) && (in_hdr || out_ready);

  assign last_pop  = mst_rx_pop && (pos == burst - 1'b1);
  assign plan_load = accept && !zero_req;
  assign plan_adv  = last_pop && !last_chunk;

  sfr_chunk_plan #(
    .LEN_W    (LEN_W),
    .LVL_W    (LVL_W),
    .CHUNK_MAX(CHUNK_MAX)
  ) u_plan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (plan_load),
    .advance   (plan_adv),
    .ld_addr   (req_addr),
    .ld_len    (req_len),
    .cur_addr  (cur_addr),
    .chunk_len (chunk_len),
    .last_chunk(last_chunk)
  );

  sfr_gap_timer #(
    .GAP_CYC(GAP_CYC)
  ) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (gap_start),
    .elapsed(gap_elapsed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pos   <= '0;
      done  <= 1'b0;
    end else begin
      done <= zero_req || (last_pop && last_chunk);
      case (state)
        ST_IDLE: if (plan_load) state <= ST_GAP;
        ST_GAP: if (gap_elapsed) begin
          state <= ST_LOAD;
          pos   <= '0;
        end
        ST_LOAD: begin
          pos <= pos + 1'b1;
          if (pos == LVL_W'(HDR_BYTES - 1)) state <= ST_GO;
        end
        ST_GO: state <= ST_WAIT;
        ST_WAIT: if (fill_ok) begin
          state <= ST_DRAIN;
          pos   <= '0;
        end
        ST_DRAIN: if (mst_rx_pop) begin
          pos <= pos + 1'b1;
          if (last_pop) state <= last_chunk ? ST_IDLE : ST_GAP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- observation logic for the assertions ----------------
  logic          fill_seen;
  logic [GW-1:0] since_fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_seen  <= 1'b0;
      since_fill <= GW'(GAP_CYC);
    end else begin
      if (mst_start)                                    fill_seen <= 1'b0;
      else if (mst_rx_level >= mst_burst_cnt && !req_ready) fill_seen <= 1'b1;
      if (gap_start)                         since_fill <= '0;
      else if (since_fill != GW'(GAP_CYC))   since_fill <= since_fill + 1'b1;
    end
  end

  // R3: counters at the start pulse
  a_r3_counts: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |-> (mst_xfer_cnt == LVL_W'(HDR_BYTES)) && (mst_burst_cnt > LVL_W'(HDR_BYTES))
                  && (int'(mst_burst_cnt) <= FIFO_DEPTH));

  // R1: the start pulse directly follows the header pushes
  a_r1_push_then_start: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |-> $past(mst_tx_push));

  // R4: popping only once the full burst has been observed in the FIFO
  a_r4_no_early_pop: assert property (@(posedge clk) disable iff (!rst_n)
    mst_rx_pop |-> fill_seen);

  // R6: deselect gap before every start
  a_r6_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mst_start |-> (since_fill == GW'(GAP_CYC)));

  // R10: a stalled stream holds the FIFO and keeps its byte offered
  a_r10_no_pop_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !mst_rx_pop);
  a_r10_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  // R8: zero-length request finishes on the next cycle, back in idle
  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    zero_req |=> (done && req_ready && !mst_tx_push));

  // R11: no stream output while a request could be accepted
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!out_valid && !mst_rx_pop && !mst_start));

endmodule

// File: tb/spi_flash_chunk_reader_bench.sv
`timescale 1ns/1ps
module spi_flash_chunk_reader_bench;

  localparam int LEN_W = 16;
  localparam int DEPTH = 64;
  localparam int GAP   = 20;
  localparam int LW    = $clog2(DEPTH + 1);
  localparam int MAXC  = DEPTH - 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [7:0] out_data;
  logic done;
  logic [LW-1:0] mst_burst_cnt, mst_xfer_cnt;
  logic [7:0] mst_tx_data;
  logic mst_tx_push, mst_start, mst_rx_pop;
  logic [LW-1:0] mst_rx_level = '0;
  logic [7:0] mst_rx_data = '0;

  always #2.5 clk = ~clk;

  spi_flash_chunk_reader #(.LEN_W(LEN_W), .FIFO_DEPTH(DEPTH), .GAP_CYC(GAP)) u_spi_flash_chunk_reader (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done), .mst_burst_cnt(mst_burst_cnt), .mst_xfer_cnt(mst_xfer_cnt),
    .mst_tx_data(mst_tx_data), .mst_tx_push(mst_tx_push), .mst_start(mst_start),
    .mst_rx_level(mst_rx_level), .mst_rx_data(mst_rx_data), .mst_rx_pop(mst_rx_pop));

  int checks = 0, errors = 0, cycles = 0;

  // reference model state
  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [7:0] expq[$];
  int ch_addr[$];
  int ch_len[$];
  int fill_left = 0, fill_k = 0, fill_delay = 0, cur_burst = 0, since_fill = 1000;
  int fill_addr = 0;
  bit filled = 1'b0, armed = 1'b0, exp_done = 1'b0, zero_active = 1'b0, got_done = 1'b0;
  bit accepted = 1'b0;
  int stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic drv_valid = 1'b0;
  logic [23:0] drv_addr = '0;
  logic [LEN_W-1:0] drv_len = '0;

  function automatic logic [7:0] flash_byte(input int a);
    logic [23:0] x;
    x = 24'(a);
    return x[7:0] ^ x[15:8] ^ x[23:16] ^ 8'h5C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic step();
    bit s_pop, s_push, s_start, s_fire, s_acc;
    logic [7:0] s_tx;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) begin
      chk(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (stall_mode)
      0: out_ready = 1'b1;
      1: out_ready = lfsr[0] | lfsr[1];
      default: out_ready = (cycles % 9 == 0);
    endcase
    req_valid = drv_valid;
    req_addr  = drv_addr;
    req_len   = drv_len;
    #1;
    // R9 / R8: done compared every cycle with the model
    chk(done == exp_done, "R9 done timing", done, exp_done);
    if (done) got_done = 1'b1;
    s_pop = mst_rx_pop; s_push = mst_tx_push; s_start = mst_start; s_tx = mst_tx_data;
    s_fire = out_valid && out_ready;
    s_acc = req_valid && req_ready;
    exp_done = 1'b0;
    if (zero_active) begin
      chk(!(s_pop || s_push || s_start), "R8 no activity on zero length", {s_pop, s_push, s_start}, 0);
      if (done) zero_active = 1'b0;
    end
    if (s_pop) begin
      chk(filled && rxq.size() > 0, "R4 pop before full burst", rxq.size(), cur_burst);
    end
    if (out_valid && !out_ready) begin
      chk(!s_pop, "R10 pop while stalled", s_pop, 0);
    end
    if (s_fire) begin
      if (expq.size() == 0) chk(1'b0, "R5 unexpected output byte", out_data, 0);
      else begin
        chk(out_data == expq[0], "R5 payload byte", out_data, expq[0]);
        void'(expq.pop_front());
        if (expq.size() == 0) exp_done = 1'b1;
      end
    end
    if (s_start) begin
      if (ch_len.size() == 0) chk(1'b0, "R2 unexpected burst", mst_burst_cnt, 0);
      else begin
        chk(txq.size() == 4, "R1 header byte count", txq.size(), 4);
        if (txq.size() == 4) begin
          chk(txq[0] == 8'h03, "R1 opcode", txq[0], 8'h03);
          chk({txq[1], txq[2], txq[3]} == 24'(ch_addr[0]), "R7 burst address",
              {txq[1], txq[2], txq[3]}, ch_addr[0]);
          fill_addr = int'({txq[1], txq[2], txq[3]});
        end
        chk(int'(mst_burst_cnt) == ch_len[0] + 4, "R2 burst length", mst_burst_cnt, ch_len[0] + 4);
        chk(int'(mst_xfer_cnt) == 4, "R3 transmit count", mst_xfer_cnt, 4);
        chk(since_fill >= GAP, "R6 deselect gap", since_fill, GAP);
        cur_burst = int'(mst_burst_cnt);
        void'(ch_addr.pop_front());
        void'(ch_len.pop_front());
      end
    end
    if (s_acc) begin
      int a, r, c;
      accepted = 1'b1;
      a = int'(req_addr); r = int'(req_len);
      for (int i = 0; i < r; i++) expq.push_back(flash_byte((a + i) & 24'hFFFFFF));
      while (r > 0) begin
        c = (r > MAXC) ? MAXC : r;
        ch_addr.push_back(a); ch_len.push_back(c);
        a = (a + c) & 24'hFFFFFF; r -= c;
      end
      if (req_len == 0) begin exp_done = 1'b1; zero_active = 1'b1; end
    end
    @(posedge clk);
    #1;
    if (s_pop && rxq.size() > 0) void'(rxq.pop_front());
    if (s_push) txq.push_back(s_tx);
    if (s_start) begin
      txq.delete();
      armed = 1'b1; filled = 1'b0;
      fill_left = cur_burst; fill_k = 0; fill_delay = 2;
    end else if (fill_delay > 0) fill_delay--;
    else if (fill_left > 0) begin
      rxq.push_back(fill_k < 4 ? 8'hEE : flash_byte((fill_addr + fill_k - 4) & 24'hFFFFFF));
      fill_k++; fill_left--;
    end
    if (armed && !filled && rxq.size() >= cur_burst) begin
      filled = 1'b1; since_fill = 0;
    end else since_fill++;
    mst_rx_level = LW'(rxq.size());
    mst_rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;
  endtask

  task automatic run_req(input logic [23:0] a, input int l);
    int t;
    drv_addr = a; drv_len = LEN_W'(l); drv_valid = 1'b1;
    accepted = 1'b0; got_done = 1'b0;
    t = 0;
    while (!accepted && t < 1000) begin step(); t++; end
    drv_valid = 1'b0;
    chk(accepted, "R11 request accepted", accepted, 1);
    t = 0;
    while (!got_done && t < 20000) begin step(); t++; end
    chk(got_done, "R9 request completes", got_done, 1);
    chk(expq.size() == 0 && ch_len.size() == 0, "R5 all bytes delivered", expq.size(), 0);
    for (int i = 0; i < 3; i++) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk(req_ready == 1'b1, "R11 req_ready at reset", req_ready, 1);
    chk(!out_valid && !done, "R11 outputs idle at reset", {out_valid, done}, 0);
    chk(!mst_tx_push && !mst_start && !mst_rx_pop, "R11 master idle at reset",
        {mst_tx_push, mst_start, mst_rx_pop}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    // R8: zero length
    run_req(24'h123456, 0);
    // short request, always ready
    run_req(24'h000100, 5);
    // R2 exact full burst, address carry inside
    run_req(24'h00FFF0, 60);
    // R2 one over: 60 + 1; R6 short remainder drains before the gap ends
    run_req(24'h0200F8, 61);
    // R7 address wrap across the 24-bit top
    run_req(24'hFFFFC0, 150);
    // R10 random stalls
    stall_mode = 1;
    run_req(24'h3A0007, 130);
    // R6 / R10 heavy stall: gap expires long before the drain ends
    stall_mode = 2;
    run_req(24'h7FFFE2, 70);
    // back to back: zero length, then a tiny one
    stall_mode = 0;
    run_req(24'hABCDEF, 0);
    run_req(24'hABCDEF, 3);
    finish_run();
  end

endmodule